// File: doc/BRIEF.md
# Bus Master Transfer Sequencer with Retract Recovery

This block sits between a local client and a shared system bus and runs one single or burst transfer at a time on the client's behalf. The client offers an address, a direction, a beat size and a beat count while the block shows it is free. The block then drives the transfer type and address onto the bus, one beat at a time. The first beat goes out as nonsequential and each later beat as sequential, at an address stepped by the beat size.

On every cycle of a transfer the block reads the slave's three response lines: wait, last and error. A wait-high response stretches the current beat. A done or last response finishes the beat. An error response ends the whole burst, and the client gets an error status with the index of the failing beat. A slave may first give a warning that a retract is coming and then give the retract itself. In that case the block does not count the beat as finished. It puts the same beat out again as a fresh nonsequential transfer at the same address, and the number of beats still to run is unchanged. When the transfer ends, the block gives the client a single-cycle completion pulse.

Top module: `bus_master_resp`

## Requirements
- R1: After reset the block is free (`req_ready`=1), `bus_tran` is idle (2'b00) and `cmp_valid` is 0.
- R2: A `req_valid` taken while free makes the next cycle drive `bus_tran`=2'b10 (nonsequential), `bus_addr`=`req_addr`, `bus_write` and `bus_size` from the request, with `req_ready`=0.
- R3: A response with wait high (wait/last/error = 1/0/0) holds `bus_addr` and `bus_tran` unchanged in the next cycle and gives no completion.
- R4: A DONE response (0/0/0) on a beat that is not the last one moves the next cycle to `bus_tran`=2'b11 (sequential) at the address plus 2^`bus_size` bytes (`req_size`: 0=byte, 1=halfword, 2=word).
- R5: A DONE or LAST response on the final beat (beat count is `req_beats_m1`+1) gives a one-cycle `cmp_valid` pulse with `cmp_error`=0 in the next cycle, and the block is free again.
- R6: A LAST response (0/1/0) is handled exactly like DONE.
- R7: An ERROR response (0/0/1) ends the burst at once. The next cycle shows `cmp_valid`=1, `cmp_error`=1 and `cmp_beat` set to the zero-based index of the failing beat.
- R8: A retract warning (1/1/1) stretches the beat like a wait. The first later response with wait low is then treated as a retract, whatever its last and error levels, and is never taken as completion.
- R9: A retract (0/1/1) makes the next cycle reissue the same beat as nonsequential (2'b10) at the same address. The beats still to run are unchanged.
- R10: `req_valid` while a transfer is running is ignored. It changes neither the bus address nor the number of beats, and no transfer follows the completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Client offers a transfer |
| req_addr | input | ADDR_W | Start address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Beat size: 0 byte, 1 halfword, 2 word |
| req_beats_m1 | input | LEN_W | Beat count minus one |
| req_ready | output | 1 | Block is free to take a request |
| bus_tran | output | 2 | Transfer type: 00 idle, 10 nonsequential, 11 sequential |
| bus_addr | output | ADDR_W | Current beat address |
| bus_write | output | 1 | Direction of the current transfer |
| bus_size | output | 2 | Beat size of the current transfer |
| rsp_wait | input | 1 | Slave response wait line |
| rsp_last | input | 1 | Slave response last line |
| rsp_error | input | 1 | Slave response error line |
| cmp_valid | output | 1 | One-cycle completion pulse |
| cmp_error | output | 1 | Completion was an error |
| cmp_beat | output | LEN_W | Index of the final or failing beat |

## Verification
The main walk sends bursts of one to four beats at byte, halfword and word sizes, with zero to two wait cycles on each beat and LAST given on odd beats. This separates address stepping by size from beat counting, and shows that waits stretch a beat without moving it. Errors placed on the first and on a middle beat check both early abort and the reported beat index. The retract cases use a warning followed by the proper retract code, and a warning followed by a plain done code. They tell a correct reissue with a preserved count apart from a beat that is wrongly finished or skipped.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } bus_tran_t;

  typedef enum logic [2:0] {
    RK_WAIT,
    RK_RETNEXT,
    RK_DONE,
    RK_ERROR,
    RK_RETRACT
  } rsp_kind_t;
endpackage

// File: rtl/bmr_rsp_classify.sv
module bmr_rsp_classify
  import bmr_pkg::*;
(
  input  logic      rsp_wait,
  input  logic      rsp_last,
  input  logic      rsp_error,
  input  logic      retnext_pend,
  output rsp_kind_t kind
);
  always_comb begin
    if (retnext_pend && !rsp_wait)             kind = RK_RETRACT;
    else if (rsp_wait && rsp_last && rsp_error) kind = RK_RETNEXT;
    else if (rsp_wait)                          kind = RK_WAIT;
    else if (rsp_last && rsp_error)             kind = RK_RETRACT;
    else if (rsp_error)                         kind = RK_ERROR;
    else                                        kind = RK_DONE;
  end
endmodule

// File: rtl/bmr_addr_track.sv
module bmr_addr_track #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [LEN_W-1:0]  req_beats_m1,
  output logic [ADDR_W-1:0] addr_q,
  output logic              write_q,
  output logic [1:0]        size_q,
  output logic [LEN_W-1:0]  beat_q,
  output logic              is_final
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [LEN_W-1:0]  BEAT_ONE = {{(LEN_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] addr_d;
  logic              write_d;
  logic [1:0]        size_d;
  logic [LEN_W-1:0]  beat_d, len_q, len_d;

  always_comb begin
    addr_d  = addr_q;
    write_d = write_q;
    size_d  = size_q;
    beat_d  = beat_q;
    len_d   = len_q;
    if (load) begin
      addr_d  = req_addr;
      write_d = req_write;
      size_d  = req_size;
      beat_d  = '0;
      len_d   = req_beats_m1;
    end else if (advance) begin
      addr_d = addr_q + (ONE << size_q);
      beat_d = beat_q + BEAT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      write_q <= 1'b0;
      size_q  <= 2'b00;
      beat_q  <= '0;
      len_q   <= '0;
    end else if (load || advance) begin
      addr_q  <= addr_d;
      write_q <= write_d;
      size_q  <= size_d;
      beat_q  <= beat_d;
      len_q   <= len_d;
    end
  end

  assign is_final = (beat_q == len_q);
endmodule

// File: rtl/bmr_ctrl.sv
module bmr_ctrl
  import bmr_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  rsp_kind_t        kind,
  input  logic             is_final,
  input  logic [LEN_W-1:0] beat,
  output logic             busy,
  output logic             first,
  output logic             retnext_pend,
  output logic             load,
  output logic             advance,
  output logic             cmp_valid,
  output logic             cmp_error,
  output logic [LEN_W-1:0] cmp_beat
);
  typedef enum logic {ST_IDLE, ST_BUSY} st_t;

  st_t              st_q, st_d;
  logic             first_d, pend_d, cv_d, ce_d;
  logic [LEN_W-1:0] cb_d;

  always_comb begin
    st_d    = st_q;
    first_d = first;
    pend_d  = retnext_pend;
    cv_d    = 1'b0;
    ce_d    = cmp_error;
    cb_d    = cmp_beat;
    load    = 1'b0;
    advance = 1'b0;
    if (st_q == ST_IDLE) begin
      if (req_valid) begin
        load    = 1'b1;
        st_d    = ST_BUSY;
        first_d = 1'b1;
        pend_d  = 1'b0;
      end
    end else begin
      unique case (kind)
        RK_WAIT:    ;
        RK_RETNEXT: pend_d = 1'b1;
        RK_RETRACT: begin
          pend_d  = 1'b0;
          first_d = 1'b1;
        end
        RK_ERROR: begin
          st_d = ST_IDLE;
          cv_d = 1'b1;
          ce_d = 1'b1;
          cb_d = beat;
        end
        RK_DONE: begin
          if (is_final) begin
            st_d = ST_IDLE;
            cv_d = 1'b1;
            ce_d = 1'b0;
            cb_d = beat;
          end else begin
            advance = 1'b1;
            first_d = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      first        <= 1'b0;
      retnext_pend <= 1'b0;
      cmp_valid    <= 1'b0;
      cmp_error    <= 1'b0;
      cmp_beat     <= '0;
    end else begin
      st_q         <= st_d;
      first        <= first_d;
      retnext_pend <= pend_d;
      cmp_valid    <= cv_d;
      cmp_error    <= ce_d;
      cmp_beat     <= cb_d;
    end
  end

  assign busy = (st_q == ST_BUSY);
endmodule

// File: rtl/bus_master_resp.sv
module bus_master_resp
  import bmr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [LEN_W-1:0]  req_beats_m1,
  output logic              req_ready,
  output logic [1:0]        bus_tran,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_write,
  output logic [1:0]        bus_size,
  input  logic              rsp_wait,
  input  logic              rsp_last,
  input  logic              rsp_error,
  output logic              cmp_valid,
  output logic              cmp_error,
  output logic [LEN_W-1:0]  cmp_beat
);
  rsp_kind_t        kind;
  logic             busy, first, pend, load, advance, is_final;
  logic [LEN_W-1:0] beat;

  bmr_rsp_classify u_cls (
    .rsp_wait     (rsp_wait),
    .rsp_last     (rsp_last),
    .rsp_error    (rsp_error),
    .retnext_pend (pend),
    .kind         (kind)
  );

  bmr_addr_track #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_trk (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (load),
    .advance      (advance),
    .req_addr     (req_addr),
    .req_write    (req_write),
    .req_size     (req_size),
    .req_beats_m1 (req_beats_m1),
    .addr_q       (bus_addr),
    .write_q      (bus_write),
    .size_q       (bus_size),
    .beat_q       (beat),
    .is_final     (is_final)
  );

  bmr_ctrl #(.LEN_W(LEN_W)) u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .kind         (kind),
    .is_final     (is_final),
    .beat         (beat),
    .busy         (busy),
    .first        (first),
    .retnext_pend (pend),
    .load         (load),
    .advance      (advance),
    .cmp_valid    (cmp_valid),
    .cmp_error    (cmp_error),
    .cmp_beat     (cmp_beat)
  );

  assign req_ready = !busy;
  assign bus_tran  = !busy ? TR_IDLE : (first ? TR_NONSEQ : TR_SEQ);
endmodule

// File: rtl/bmr_checker.sv
module bmr_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic [1:0]        bus_tran,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              rsp_wait,
  input logic              rsp_last,
  input logic              rsp_error,
  input logic              cmp_valid,
  input logic              cmp_error
);
  // R1 / R2: idle type exactly when free
  p_idle_when_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> bus_tran == 2'b00);

  // R3: wait-high holds the beat
  p_wait_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && rsp_wait) |=> ($stable(bus_addr) && $stable(bus_tran) && !cmp_valid));

  // R5: completion only after a wait-low response, and the block is free
  p_cmp_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |-> ($past(!rsp_wait) && $past(!req_ready) && req_ready));

  // R7: error completion traces back to the error code
  p_err_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_error) |-> $past(rsp_error && !rsp_last && !rsp_wait));

  // R8: a warning never completes in the next cycle
  p_retnext_no_cmp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && rsp_wait && rsp_last && rsp_error) |=> !cmp_valid);

  // R9: retract reissues the same beat as nonsequential
  p_retract_reissue_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !rsp_wait && rsp_last && rsp_error) |=>
      (bus_tran == 2'b10 && $stable(bus_addr) && !cmp_valid));
endmodule

bind bus_master_resp bmr_checker #(.ADDR_W(ADDR_W)) u_bmr_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .bus_tran  (bus_tran),
  .bus_addr  (bus_addr),
  .rsp_wait  (rsp_wait),
  .rsp_last  (rsp_last),
  .rsp_error (rsp_error),
  .cmp_valid (cmp_valid),
  .cmp_error (cmp_error)
);

// File: tb/bus_master_resp_tb_top.sv
module bus_master_resp_tb_top;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 4;
  localparam int NVEC   = 5;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic [ADDR_W-1:0] req_addr;
  logic              req_write;
  logic [1:0]        req_size;
  logic [LEN_W-1:0]  req_beats_m1;
  logic              req_ready;
  logic [1:0]        bus_tran;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_write;
  logic [1:0]        bus_size;
  logic              rsp_wait, rsp_last, rsp_error;
  logic              cmp_valid, cmp_error;
  logic [LEN_W-1:0]  cmp_beat;

  int checks   = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  bus_master_resp #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .req_size(req_size), .req_beats_m1(req_beats_m1), .req_ready(req_ready),
    .bus_tran(bus_tran), .bus_addr(bus_addr), .bus_write(bus_write), .bus_size(bus_size),
    .rsp_wait(rsp_wait), .rsp_last(rsp_last), .rsp_error(rsp_error),
    .cmp_valid(cmp_valid), .cmp_error(cmp_error), .cmp_beat(cmp_beat)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  size;
    logic [3:0]  m1;
    logic        err_en;
    logic [3:0]  err_beat;
    logic [1:0]  waits;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{32'h0000_0100, 2'd2, 4'd0, 1'b0, 4'd0, 2'd0},
    '{32'h0000_0200, 2'd2, 4'd3, 1'b0, 4'd0, 2'd1},
    '{32'h0000_0301, 2'd0, 4'd2, 1'b0, 4'd0, 2'd2},
    '{32'h0000_0400, 2'd1, 4'd3, 1'b1, 4'd2, 2'd0},
    '{32'h0000_0500, 2'd2, 4'd1, 1'b1, 4'd0, 2'd1}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rsp(input logic w, input logic l, input logic e);
    rsp_wait = w; rsp_last = l; rsp_error = e;
    @(negedge clk);
  endtask

  task automatic issue(input logic [31:0] a, input logic [1:0] s, input logic [3:0] m1, input logic wr);
    req_valid = 1'b1; req_addr = a; req_size = s; req_beats_m1 = m1; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
    req_size = 2'd0; req_beats_m1 = '0;
    rsp_wait = 1'b0; rsp_last = 1'b0; rsp_error = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ready at reset", req_ready, 1);
    chk("R1 tran idle at reset", bus_tran, 0);
    chk("R1 no cmp at reset", cmp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      int last_b;
      logic [31:0] exp_a;
      v = VEC[i];
      last_b = v.err_en ? int'(v.err_beat) : int'(v.m1);
      issue(v.addr, v.size, v.m1, i[0]);
      chk("R2 busy after accept", req_ready, 0);
      chk("R2 write copied", bus_write, i[0]);
      chk("R2 size copied", bus_size, v.size);
      for (int b = 0; b <= last_b; b++) begin
        exp_a = v.addr + (32'(b) << v.size);
        for (int w = 0; w < int'(v.waits); w++) begin
          chk("R3 addr held on wait", bus_addr, exp_a);
          rsp(1'b1, 1'b0, 1'b0);
        end
        chk(b == 0 ? "R2 first beat nonseq" : "R4 later beat seq", bus_tran, b == 0 ? 2 : 3);
        chk("R4 beat address", bus_addr, exp_a);
        chk("R3 no cmp mid burst", cmp_valid, 0);
        if (v.err_en && b == int'(v.err_beat)) rsp(1'b0, 1'b0, 1'b1);
        else if (b % 2 == 1) rsp(1'b0, 1'b1, 1'b0);   // R6 LAST
        else rsp(1'b0, 1'b0, 1'b0);
      end
      chk("R5 cmp pulse", cmp_valid, 1);
      chk("R7 cmp_error", cmp_error, v.err_en);
      if (v.err_en) chk("R7 failing beat index", cmp_beat, v.err_beat);
      chk("R5 free at completion", req_ready, 1);
      rsp(1'b0, 1'b0, 1'b0);
      chk("R5 cmp single cycle", cmp_valid, 0);
      chk("R1 idle after completion", bus_tran, 0);
    end

    // R9: warning then retract on beat 1 of a 3-beat burst
    issue(32'h800, 2'd2, 4'd2, 1'b0);
    rsp(1'b0, 1'b0, 1'b0);
    chk("R4 seq before retract", bus_tran, 3);
    chk("R4 addr before retract", bus_addr, 32'h804);
    rsp(1'b1, 1'b1, 1'b1);
    chk("R8 warning no cmp", cmp_valid, 0);
    rsp(1'b0, 1'b1, 1'b1);
    chk("R9 reissue nonseq", bus_tran, 2);
    chk("R9 reissue same addr", bus_addr, 32'h804);
    chk("R9 no cmp on retract", cmp_valid, 0);
    rsp(1'b0, 1'b0, 1'b0);
    chk("R9 next beat seq", bus_tran, 3);
    chk("R9 next beat addr", bus_addr, 32'h808);
    chk("R9 count kept, not done yet", cmp_valid, 0);
    rsp(1'b0, 1'b0, 1'b0);
    chk("R9 completes after remaining beat", cmp_valid, 1);
    chk("R9 ok status", cmp_error, 0);
    rsp(1'b0, 1'b0, 1'b0);

    // R8: warning followed by a plain done code is still a retract
    issue(32'hA00, 2'd2, 4'd0, 1'b1);
    rsp(1'b1, 1'b1, 1'b1);
    rsp(1'b0, 1'b0, 1'b0);
    chk("R8 done after warning not completion", cmp_valid, 0);
    chk("R8 reissue nonseq", bus_tran, 2);
    chk("R8 same addr", bus_addr, 32'hA00);
    rsp(1'b0, 1'b0, 1'b0);
    chk("R8 completes on second done", cmp_valid, 1);
    rsp(1'b0, 1'b0, 1'b0);

    // R10: request while busy is ignored
    issue(32'hC00, 2'd2, 4'd1, 1'b0);
    req_valid = 1'b1; req_addr = 32'hDEAD_0000; req_beats_m1 = 4'd7;
    rsp(1'b1, 1'b0, 1'b0);
    chk("R10 addr unchanged by busy req", bus_addr, 32'hC00);
    rsp(1'b0, 1'b0, 1'b0);
    req_valid = 1'b0;
    chk("R10 addr step from original", bus_addr, 32'hC04);
    rsp(1'b0, 1'b0, 1'b0);
    chk("R10 original length kept", cmp_valid, 1);
    rsp(1'b0, 1'b0, 1'b0);
    chk("R10 no queued transfer", bus_tran, 0);

    // R1: reset in the middle of a burst
    issue(32'hE00, 2'd2, 4'd3, 1'b0);
    rsp(1'b1, 1'b0, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 ready after mid reset", req_ready, 1);
    chk("R1 idle after mid reset", bus_tran, 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule